// File: doc/BRIEF.md
# Multi-Context Branch Target Predictor

This block guesses where instruction fetch goes next for a core that runs several hardware thread contexts at once. One lookup port presents a context number, a fetch address and the kind of control transfer found there. In the same cycle the block returns a taken/not-taken guess and, where it can, a target address. A second port trains the block with resolved results from the back end.

Conditional branches are predicted by a single direction table that all contexts share. It holds 2-bit saturating counters, carries no tags and is indexed directly by address bits. Subroutine returns are predicted from a return address stack. Each context has its own stack, and calls push onto it at lookup time. Computed jumps are predicted from a small table that holds the most recent resolved target for each slot. All tables are flops, and lookups read the state as it stood at the start of the cycle.

Top module: `ctx_branch_predictor`

## Requirements
- R1: After reset every direction counter holds 1, so every conditional lookup predicts not-taken. Every return stack is empty, so a return lookup gives target 0 with the target-valid output low. Every jump-table slot is invalid, so a jump lookup has target-valid low.
- R2: Kind encoding is 0 conditional, 1 call, 2 return, 3 computed jump. A conditional lookup predicts taken when its counter is 2 or 3. A resolved conditional update adds 1 when taken and subtracts 1 when not taken, and the counter stays within 0 and 3.
- R3: The direction table has 2048 entries indexed by PC[12:2] with no tag. Two branches whose PCs differ only above bit 12 share one counter.
- R4: Each of the 8 contexts has its own return stack. A call or return in one context does not change what another context's return lookup yields.
- R5: A call lookup pushes PC+4 onto its context's stack. A return lookup pops that stack, and the target output is the popped value, in last-in first-out order. Call, conditional and jump lookups also drive taken high for call and jump, with target-valid low for call.
- R6: A stack holds 12 entries. A 13th push without a pop overwrites the oldest entry, so the next 12 returns yield the 12 newest addresses, newest first, and the 13th return finds the stack empty.
- R7: A return lookup on an empty stack yields target 0 with target-valid low and leaves the stack unchanged.
- R8: The jump table has 32 slots indexed by PC[6:2]. Every resolved computed-jump update overwrites its slot with the resolved target and marks the slot valid. A jump lookup returns the slot's target and valid bit, and taken is high.
- R9: When a lookup and an update address the same counter or jump slot in one cycle, the lookup returns the value held before the update.
- R10: With the lookup valid input low, all prediction outputs are 0 and no return stack changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_ctx_i | input | 3 | Context issuing the lookup |
| lk_pc_i | input | 32 | Address of the control-transfer instruction |
| lk_kind_i | input | 2 | Transfer kind (0 cond, 1 call, 2 return, 3 jump) |
| upd_valid_i | input | 1 | Resolved result present this cycle |
| upd_pc_i | input | 32 | Address of the resolved instruction |
| upd_kind_i | input | 2 | Kind of the resolved instruction |
| upd_taken_i | input | 1 | Resolved direction of a conditional branch |
| upd_target_i | input | 32 | Resolved target of a computed jump |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | 32 | Predicted target address |
| pred_tgt_valid_o | output | 1 | The predicted target is meaningful |

## Verification
The prediction outputs are combinational from the lookup inputs and the stored state. Every result is therefore due in the same cycle its lookup is driven, and every state change (counter step, push, pop, slot write) is first visible on the lookup that follows the next rising edge. The bench drives each request on a falling edge, samples the outputs one nanosecond later, and lets the rising edge commit the request before the next one starts. The same-cycle cases under R9 drive both ports within one low phase: the old value is read before the edge and the new value on the following lookup.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BR_COND = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2,
    BR_JUMP = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            taken_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0]       ctr_q [ENTRIES];
  logic [IDX_W-1:0] lk_idx, upd_idx;

  assign lk_idx  = lk_pc_i[IDX_W+1:2];
  assign upd_idx = upd_pc_i[IDX_W+1:2];
  assign taken_o = ctr_q[lk_idx][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'd1;
    end else if (upd_en_i) begin
      if (upd_taken_i && ctr_q[upd_idx] != 2'd3)
        ctr_q[upd_idx] <= ctr_q[upd_idx] + 2'd1;
      else if (!upd_taken_i && ctr_q[upd_idx] != 2'd0)
        ctr_q[upd_idx] <= ctr_q[upd_idx] - 2'd1;
    end
  end

  // R2: a taken update never leaves the counter at 0, a not-taken never at 3
  p_taken_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i |=> ctr_q[$past(upd_idx)] != 2'd0);
  p_ntaken_nonmax_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i |=> ctr_q[$past(upd_idx)] != 2'd3);
  // R2: saturation at the top
  p_sat_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && ctr_q[upd_idx] == 2'd3 |=> ctr_q[$past(upd_idx)] == 2'd3);
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_addr_i,
  output logic [PC_W-1:0] top_o,
  output logic            top_valid_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr;   // wr_ptr_q: next free slot (circular)
  logic [CNT_W-1:0] cnt_q;

  assign rd_ptr      = (wr_ptr_q == '0) ? LAST : wr_ptr_q - PTR_W'(1);
  assign top_valid_o = cnt_q != '0;
  assign top_o       = top_valid_o ? mem_q[rd_ptr] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      mem_q[wr_ptr_q] <= push_addr_i;
      wr_ptr_q        <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
      if (cnt_q != FULL) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && top_valid_o) begin
      wr_ptr_q <= rd_ptr;
      cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_push_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && cnt_q == FULL |=> cnt_q == FULL);
  p_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && cnt_q == '0 |=> cnt_q == '0 && $stable(wr_ptr_q));
  p_push_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_valid_o && top_o == $past(push_addr_i));
endmodule

// File: rtl/bp_jump_table.sv
module bp_jump_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic [PC_W-1:0] tgt_o,
  output logic            tgt_valid_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_tgt_i
);
  localparam int SLOTS = 1 << IDX_W;

  logic [PC_W-1:0]  tgt_q [SLOTS];
  logic [SLOTS-1:0] vld_q;
  logic [IDX_W-1:0] lk_idx, upd_idx;

  assign lk_idx      = lk_pc_i[IDX_W+1:2];
  assign upd_idx     = upd_pc_i[IDX_W+1:2];
  assign tgt_o       = tgt_q[lk_idx];
  assign tgt_valid_o = vld_q[lk_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) tgt_q[i] <= '0;
      vld_q <= '0;
    end else if (upd_en_i) begin
      tgt_q[upd_idx] <= upd_tgt_i;
      vld_q[upd_idx] <= 1'b1;
    end
  end

  p_last_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> vld_q[$past(upd_idx)] && tgt_q[$past(upd_idx)] == $past(upd_tgt_i));
endmodule

// File: rtl/ctx_branch_predictor.sv
module ctx_branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int NUM_CTX   = 8,
  parameter int RAS_DEPTH = 12,
  parameter int DIR_IDX_W = 11,
  parameter int JT_IDX_W  = 5,
  localparam int CTX_W    = $clog2(NUM_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [CTX_W-1:0] lk_ctx_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [1:0]       lk_kind_i,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [1:0]       upd_kind_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_target_i,
  output logic             pred_taken_o,
  output logic [PC_W-1:0]  pred_target_o,
  output logic             pred_tgt_valid_o
);
  br_kind_e lk_kind, upd_kind;
  assign lk_kind  = br_kind_e'(lk_kind_i);
  assign upd_kind = br_kind_e'(upd_kind_i);

  logic dir_taken;
  bp_dir_table #(.PC_W(PC_W), .IDX_W(DIR_IDX_W)) u_dir (
    .clk_i, .rst_ni,
    .lk_pc_i     (lk_pc_i),
    .taken_o     (dir_taken),
    .upd_en_i    (upd_valid_i && upd_kind == BR_COND),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i)
  );

  logic [PC_W-1:0] jt_tgt;
  logic            jt_vld;
  bp_jump_table #(.PC_W(PC_W), .IDX_W(JT_IDX_W)) u_jt (
    .clk_i, .rst_ni,
    .lk_pc_i     (lk_pc_i),
    .tgt_o       (jt_tgt),
    .tgt_valid_o (jt_vld),
    .upd_en_i    (upd_valid_i && upd_kind == BR_JUMP),
    .upd_pc_i    (upd_pc_i),
    .upd_tgt_i   (upd_target_i)
  );

  logic [PC_W-1:0]    ras_top [NUM_CTX];
  logic [NUM_CTX-1:0] ras_vld, ras_push, ras_pop;
  logic [PC_W-1:0]    ret_addr;
  assign ret_addr = lk_pc_i + PC_W'(4);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assign ras_push[c] = lk_valid_i && lk_kind == BR_CALL && lk_ctx_i == CTX_W'(c);
    assign ras_pop[c]  = lk_valid_i && lk_kind == BR_RET  && lk_ctx_i == CTX_W'(c);
    bp_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk_i, .rst_ni,
      .push_i      (ras_push[c]),
      .pop_i       (ras_pop[c]),
      .push_addr_i (ret_addr),
      .top_o       (ras_top[c]),
      .top_valid_o (ras_vld[c])
    );
  end

  always_comb begin
    pred_taken_o     = 1'b0;
    pred_target_o    = '0;
    pred_tgt_valid_o = 1'b0;
    if (lk_valid_i) begin
      unique case (lk_kind)
        BR_COND: pred_taken_o = dir_taken;
        BR_CALL: pred_taken_o = 1'b1;
        BR_RET: begin
          pred_taken_o     = 1'b1;
          pred_target_o    = ras_top[lk_ctx_i];
          pred_tgt_valid_o = ras_vld[lk_ctx_i];
        end
        BR_JUMP: begin
          pred_taken_o     = 1'b1;
          pred_target_o    = jt_tgt;
          pred_tgt_valid_o = jt_vld;
        end
        default: ;
      endcase
    end
  end

  // R4: at most one context's stack moves per cycle
  p_one_ctx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ras_push | ras_pop));
  // R10: idle lookup port drives nothing
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !pred_taken_o && !pred_tgt_valid_o && pred_target_o == '0);
endmodule

// File: tb/sim_ctx_branch_predictor.sv
`timescale 1ns/1ps
module sim_ctx_branch_predictor;
  localparam logic [1:0] K_COND = 2'd0, K_CALL = 2'd1, K_RET = 2'd2, K_JMP = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [2:0]  lk_ctx = '0;
  logic [31:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic [1:0]  lk_kind = '0, upd_kind = '0;
  logic        p_taken, p_vld;
  logic [31:0] p_tgt;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctx_branch_predictor u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_ctx_i(lk_ctx), .lk_pc_i(lk_pc), .lk_kind_i(lk_kind),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_kind_i(upd_kind),
    .upd_taken_i(upd_taken), .upd_target_i(upd_target),
    .pred_taken_o(p_taken), .pred_target_o(p_tgt), .pred_tgt_valid_o(p_vld)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // lookup: driven at negedge, sampled 1 ns later, committed at posedge
  task automatic look(logic [2:0] ctx, logic [31:0] pc, logic [1:0] kind);
    @(negedge clk);
    lk_valid = 1'b1; lk_ctx = ctx; lk_pc = pc; lk_kind = kind;
    #1;
    @(posedge clk); #1 lk_valid = 1'b0;
  endtask

  task automatic upd(logic [31:0] pc, logic [1:0] kind, logic tk, logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_kind = kind; upd_taken = tk; upd_target = tgt;
    @(posedge clk); #1 upd_valid = 1'b0;
  endtask

  task automatic look_chk(string req, logic [2:0] ctx, logic [31:0] pc, logic [1:0] kind,
                          logic et, logic [31:0] etgt, logic ev);
    @(negedge clk);
    lk_valid = 1'b1; lk_ctx = ctx; lk_pc = pc; lk_kind = kind;
    #1;
    chk({req, " taken"}, {31'b0, p_taken}, {31'b0, et});
    chk({req, " target"}, p_tgt, etgt);
    chk({req, " tvalid"}, {31'b0, p_vld}, {31'b0, ev});
    @(posedge clk); #1 lk_valid = 1'b0;
  endtask

  task automatic t_reset_r1;
    look_chk("R1 cond", 3'd0, 32'h100, K_COND, 1'b0, 32'h0, 1'b0);
    look_chk("R1 jump", 3'd0, 32'h104, K_JMP, 1'b1, 32'h0, 1'b0);
    look_chk("R1 ret",  3'd0, 32'h108, K_RET, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_counter_r2;
    upd(32'h200, K_COND, 1'b1, 0);
    look_chk("R2 1->2", 3'd0, 32'h200, K_COND, 1'b1, 0, 1'b0);
    upd(32'h200, K_COND, 1'b1, 0); upd(32'h200, K_COND, 1'b1, 0);
    upd(32'h200, K_COND, 1'b0, 0);
    look_chk("R2 sat3->2", 3'd0, 32'h200, K_COND, 1'b1, 0, 1'b0);
    upd(32'h200, K_COND, 1'b0, 0);
    look_chk("R2 2->1", 3'd0, 32'h200, K_COND, 1'b0, 0, 1'b0);
    for (int i = 0; i < 3; i++) upd(32'h200, K_COND, 1'b0, 0);
    upd(32'h200, K_COND, 1'b1, 0);
    look_chk("R2 sat0->1", 3'd0, 32'h200, K_COND, 1'b0, 0, 1'b0);
  endtask

  task automatic t_alias_r3;
    upd(32'h300, K_COND, 1'b1, 0);
    look_chk("R3 alias", 3'd0, 32'h2300, K_COND, 1'b1, 0, 1'b0);
    look_chk("R3 neighbour", 3'd0, 32'h304, K_COND, 1'b0, 0, 1'b0);
  endtask

  task automatic t_lifo_r5;
    look_chk("R5 call", 3'd1, 32'h1000, K_CALL, 1'b1, 0, 1'b0);
    look(3'd1, 32'h2000, K_CALL);
    look_chk("R5 pop1", 3'd1, 32'h0, K_RET, 1'b1, 32'h2004, 1'b1);
    look_chk("R5 pop2", 3'd1, 32'h0, K_RET, 1'b1, 32'h1004, 1'b1);
    look_chk("R5 empty", 3'd1, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_ctx_r4;
    look(3'd2, 32'h500, K_CALL);
    look_chk("R4 other ctx", 3'd3, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
    look_chk("R4 own ctx", 3'd2, 32'h0, K_RET, 1'b1, 32'h504, 1'b1);
  endtask

  task automatic t_overflow_r6;
    for (int i = 0; i < 13; i++) look(3'd4, 32'h10000 + i * 16, K_CALL);
    for (int i = 12; i >= 1; i--)
      look_chk("R6 pop", 3'd4, 32'h0, K_RET, 1'b1, 32'h10000 + i * 16 + 4, 1'b1);
    look_chk("R6 drained", 3'd4, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_underflow_r7;
    look_chk("R7 empty", 3'd5, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
    look_chk("R7 empty again", 3'd5, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
    look(3'd5, 32'h700, K_CALL);
    look_chk("R7 after", 3'd5, 32'h0, K_RET, 1'b1, 32'h704, 1'b1);
    look_chk("R7 drained", 3'd5, 32'h0, K_RET, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_jump_r8;
    look_chk("R8 cold", 3'd0, 32'h40, K_JMP, 1'b1, 32'h0, 1'b0);
    upd(32'h40, K_JMP, 1'b0, 32'hAAAA0);
    look_chk("R8 first", 3'd0, 32'h40, K_JMP, 1'b1, 32'hAAAA0, 1'b1);
    upd(32'h40, K_JMP, 1'b0, 32'hBBBB0);
    look_chk("R8 overwrite", 3'd0, 32'h40, K_JMP, 1'b1, 32'hBBBB0, 1'b1);
    look_chk("R8 alias", 3'd0, 32'hC0, K_JMP, 1'b1, 32'hBBBB0, 1'b1);
    look_chk("R8 other slot", 3'd0, 32'h48, K_JMP, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_bypass_r9;
    @(negedge clk);
    lk_valid = 1'b1; lk_ctx = 0; lk_pc = 32'h900; lk_kind = K_COND;
    upd_valid = 1'b1; upd_pc = 32'h900; upd_kind = K_COND; upd_taken = 1'b1;
    #1 chk("R9 cond old", {31'b0, p_taken}, 32'h0);
    @(posedge clk); #1 lk_valid = 1'b0; upd_valid = 1'b0;
    look_chk("R9 cond new", 3'd0, 32'h900, K_COND, 1'b1, 0, 1'b0);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = 32'h4C; lk_kind = K_JMP;
    upd_valid = 1'b1; upd_pc = 32'h4C; upd_kind = K_JMP; upd_target = 32'hCCCC0;
    #1 chk("R9 jump old", {31'b0, p_vld}, 32'h0);
    @(posedge clk); #1 lk_valid = 1'b0; upd_valid = 1'b0;
    look_chk("R9 jump new", 3'd0, 32'h4C, K_JMP, 1'b1, 32'hCCCC0, 1'b1);
  endtask

  task automatic t_idle_r10;
    look(3'd6, 32'h800, K_CALL);
    @(negedge clk);
    lk_valid = 1'b0; lk_ctx = 3'd6; lk_pc = 32'h0; lk_kind = K_RET;
    #1;
    chk("R10 idle taken", {31'b0, p_taken}, 32'h0);
    chk("R10 idle target", p_tgt, 32'h0);
    @(posedge clk);
    look_chk("R10 no pop", 3'd6, 32'h0, K_RET, 1'b1, 32'h804, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_r1();
    t_counter_r2();
    t_alias_r3();
    t_lifo_r5();
    t_ctx_r4();
    t_overflow_r6();
    t_underflow_r7();
    t_jump_r8();
    t_bypass_r9();
    t_idle_r10();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule